// File: doc/BRIEF.md
# Downspread Triangle Modulation Profile Generator

This block produces the frequency-offset word that a fractional-N feedback divider consumes to spread a synthesized clock. On each reference tick it moves a signed offset, in parts per million, along a symmetric triangle. The triangle starts at zero, walks down to a negative peak and climbs back to zero. The offset is never positive, so the output clock only ever runs at or below its nominal frequency. A modulation period lasts 444 ticks, which places the sweep near 32 kHz for a reference of about 14.3 MHz.

A two-bit code selects the peak depth. One of the four codes turns spreading off. The code is sampled only at period boundaries, and also while the block is held in reset or disabled. A depth change therefore never makes the profile jump. A one-cycle flag marks each return of the offset to zero. The downstream divider can use it to line up its own bookkeeping.

Top module: `ssDownspreadGen`

## Requirements
- R1: The offset output is never greater than zero.
- R2: Depth code 2'b00 gives a peak of -5000 ppm, 2'b01 gives -10000 ppm, 2'b10 gives -12500 ppm, and 2'b11 holds the offset at 0 for the whole period.
- R3: A period spans 444 ticks. Over the first 222 ticks the offset falls and reaches the exact peak. Over the next 222 ticks it rises back to 0.
- R4: After k ticks into the descent (0 ≤ k ≤ 222), or k ticks before the end of the ascent, the offset equals -floor(peak·k/222).
- R5: A change of the depth code takes effect only on the tick that ends a period. While rst is high or en is low, the code is taken as it is presented.
- R6: periodStart is high for exactly one clock after the tick that returns the offset to zero at the end of a period. It is low at every other time.
- R7: When rst (synchronous, active high) or a low en is sampled at a clock edge, the offset becomes 0, periodStart becomes 0 and the phase restarts from the beginning of a period.
- R8: A clock edge at which tick is low, with en high and rst low, leaves the offset unchanged.
- R9: The offset changes by at most ceil(12500/222) = 57 ppm per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Modulation enable; low forces zero offset and restarts the phase |
| tick | input | 1 | Reference tick; one profile step per high cycle |
| spreadSel | input | 2 | Depth code (00: 0.50 %, 01: 1.00 %, 10: 1.25 %, 11: off) |
| offsetPpm | output | 16 | Signed offset in ppm, two's complement |
| periodStart | output | 1 | One-cycle flag after the offset returns to zero |

## Verification
The assertions assume that rst is held high for at least one clock edge before they are relied on. They also assume that tick, en and spreadSel change only away from the active edge, so every edge sees a stable set of inputs. The stimulus asserts reset first and drives all inputs just after the falling edge. It mixes continuous ticks with sparse ticks, so both the stepping behaviour and the hold behaviour are observed. It also changes the depth code in the middle of a period, and drops en and rst in the middle of a period, to test the boundary latch and the restart.

// File: rtl/ssModPkg.sv
package ssModPkg;

  typedef enum logic [1:0] {
    SEL_SHALLOW = 2'b00,
    SEL_MEDIUM  = 2'b01,
    SEL_DEEP    = 2'b10,
    SEL_OFF     = 2'b11
  } spreadSel_e;

  // Strobes from the sequencer to the offset datapath
  typedef struct packed {
    logic clear;    // rst or disable: zero everything, take new code
    logic advance;  // one profile step this cycle
    logic descend;  // step goes deeper (first half of period)
    logic wrap;     // step that closes the period
  } seqStrobe_t;

endpackage

// File: rtl/ssSeqCtrl.sv
module ssSeqCtrl
  import ssModPkg::*;
#(
  parameter int PERIOD_TICKS = 444
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  output seqStrobe_t strobe,
  output logic       periodStart
);

  localparam int HALF_TICKS = PERIOD_TICKS / 2;
  localparam int PHASE_W    = $clog2(PERIOD_TICKS);

  logic [PHASE_W-1:0] phase;

  always_comb begin
    strobe.clear   = rst | ~en;
    strobe.advance = tick & ~strobe.clear;
    strobe.wrap    = strobe.advance && (phase == PHASE_W'(PERIOD_TICKS - 1));
    strobe.descend = phase < PHASE_W'(HALF_TICKS);
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      phase <= '0;
    end else if (strobe.wrap) begin
      phase <= '0;
    end else if (strobe.advance) begin
      phase <= phase + PHASE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) periodStart <= 1'b0;
    else              periodStart <= strobe.wrap;
  end

endmodule

// File: rtl/ssOffsetPath.sv
module ssOffsetPath
  import ssModPkg::*;
#(
  parameter int PERIOD_TICKS = 444,
  parameter int OFFSET_W     = 16,
  parameter int PEAK_SHALLOW = 5000,
  parameter int PEAK_MEDIUM  = 10000,
  parameter int PEAK_DEEP    = 12500
) (
  input  logic                       clk,
  input  logic [1:0]                 spreadSel,
  input  seqStrobe_t                 strobe,
  output logic signed [OFFSET_W-1:0] offsetPpm
);

  localparam int HALF_TICKS = PERIOD_TICKS / 2;
  localparam int MAG_W      = OFFSET_W - 1;
  localparam int FRAC_W     = $clog2(HALF_TICKS) + 1;

  function automatic int peakOf(input int code);
    case (code)
      0:       return PEAK_SHALLOW;
      1:       return PEAK_MEDIUM;
      2:       return PEAK_DEEP;
      default: return 0;
    endcase
  endfunction

  // Whole and fractional part of the per-tick step for each depth code
  logic [MAG_W-1:0]  quotTbl [4];
  logic [FRAC_W-1:0] remTbl  [4];

  for (genvar g = 0; g < 4; g++) begin : gStep
    assign quotTbl[g] = MAG_W'(peakOf(g) / HALF_TICKS);
    assign remTbl[g]  = FRAC_W'(peakOf(g) % HALF_TICKS);
  end

  spreadSel_e        activeSel;
  logic [MAG_W-1:0]  mag;
  logic [FRAC_W-1:0] frac;

  logic [MAG_W-1:0]  stepQ;
  logic [FRAC_W-1:0] stepR;
  logic [FRAC_W-1:0] fracSum;
  logic              carry;
  logic              borrow;

  always_comb begin
    stepQ   = quotTbl[activeSel];
    stepR   = remTbl[activeSel];
    fracSum = frac + stepR;
    carry   = fracSum >= FRAC_W'(HALF_TICKS);
    borrow  = frac < stepR;
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      activeSel <= spreadSel_e'(spreadSel);
      mag       <= '0;
      frac      <= '0;
    end else if (strobe.advance) begin
      if (strobe.wrap) begin
        activeSel <= spreadSel_e'(spreadSel);
        mag       <= '0;
        frac      <= '0;
      end else if (strobe.descend) begin
        mag  <= mag + stepQ + MAG_W'(carry);
        frac <= carry ? fracSum - FRAC_W'(HALF_TICKS) : fracSum;
      end else begin
        mag  <= mag - stepQ - MAG_W'(borrow);
        frac <= borrow ? frac + FRAC_W'(HALF_TICKS) - stepR : frac - stepR;
      end
    end
  end

  assign offsetPpm = -$signed({1'b0, mag});

endmodule

// File: rtl/ssDownspreadGen.sv
module ssDownspreadGen
  import ssModPkg::*;
#(
  parameter int PERIOD_TICKS = 444,
  parameter int OFFSET_W     = 16,
  parameter int PEAK_SHALLOW = 5000,
  parameter int PEAK_MEDIUM  = 10000,
  parameter int PEAK_DEEP    = 12500
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic                       tick,
  input  logic [1:0]                 spreadSel,
  output logic signed [OFFSET_W-1:0] offsetPpm,
  output logic                       periodStart
);

  seqStrobe_t strobe;

  ssSeqCtrl #(
    .PERIOD_TICKS(PERIOD_TICKS)
  ) seqCtrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .tick       (tick),
    .strobe     (strobe),
    .periodStart(periodStart)
  );

  ssOffsetPath #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .OFFSET_W    (OFFSET_W),
    .PEAK_SHALLOW(PEAK_SHALLOW),
    .PEAK_MEDIUM (PEAK_MEDIUM),
    .PEAK_DEEP   (PEAK_DEEP)
  ) offsetPath (
    .clk      (clk),
    .spreadSel(spreadSel),
    .strobe   (strobe),
    .offsetPpm(offsetPpm)
  );

endmodule

// File: rtl/ssDownspreadGen_chk.sv
module ssDownspreadGen_chk #(
  parameter int OFFSET_W = 16,
  parameter int MAX_STEP = 57
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       en,
  input logic                       tick,
  input logic signed [OFFSET_W-1:0] offsetPpm,
  input logic                       periodStart
);

  AST_DOWN_ONLY: assert property (@(posedge clk) disable iff (rst)
    offsetPpm <= 0);  // R1

  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    periodStart |-> offsetPpm == 0);  // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    periodStart |=> !periodStart);  // R6

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (offsetPpm == 0 && !periodStart));  // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(offsetPpm));  // R8

  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    en |=> ((int'(offsetPpm) - int'($past(offsetPpm)) <= MAX_STEP) &&
            (int'($past(offsetPpm)) - int'(offsetPpm) <= MAX_STEP)));  // R9

endmodule

bind ssDownspreadGen ssDownspreadGen_chk #(
  .OFFSET_W(OFFSET_W),
  .MAX_STEP((PEAK_DEEP + (PERIOD_TICKS / 2) - 1) / (PERIOD_TICKS / 2))
) chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .tick       (tick),
  .offsetPpm  (offsetPpm),
  .periodStart(periodStart)
);

// File: tb/ssDownspreadGen_test.sv
module ssDownspreadGen_test;

  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 444;
  localparam int HALF       = 222;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic              tick = 1'b0;
  logic [1:0]        spreadSel = 2'b00;
  logic signed [15:0] offsetPpm;
  logic              periodStart;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string reqTag = "R7";

  // Reference model state
  int mPhase = 0;
  int mSel = 0;
  int mOff = 0;
  bit mStart = 0;
  int prevOff = 0;
  bit holdExpected = 0;

  ssDownspreadGen uut (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .tick       (tick),
    .spreadSel  (spreadSel),
    .offsetPpm  (offsetPpm),
    .periodStart(periodStart)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int peakOf(input int code);
    case (code)
      0:       return 5000;
      1:       return 10000;
      2:       return 12500;
      default: return 0;
    endcase
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, actual, expected, cycles);
    end
  endtask

  // Behavioural reference: triangle index from the phase, exact floor formula
  always @(posedge clk) begin
    int k;
    cycles++;
    holdExpected = en && !rst && !tick;
    if (rst || !en) begin
      mPhase = 0;
      mSel   = int'(spreadSel);
      mOff   = 0;
      mStart = 0;
    end else if (tick) begin
      mPhase = (mPhase + 1) % PERIOD;
      mStart = (mPhase == 0);
      if (mPhase == 0) mSel = int'(spreadSel);
      k = (mPhase <= HALF) ? mPhase : PERIOD - mPhase;
      mOff = -((peakOf(mSel) * k) / HALF);
    end else begin
      mStart = 0;
    end
    if (cycles > 200000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      report();
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    check(reqTag, int'(offsetPpm), mOff);              // R4 (or stage tag)
    check("R6", int'(periodStart), int'(mStart));      // R6
    checks++;                                          // R1
    if (offsetPpm > 0) begin
      failures++;
      $display("FAIL R1 actual=%0d expected=<=0", offsetPpm);
    end
    if (holdExpected) check("R8", int'(offsetPpm), prevOff);  // R8
    if (en && !rst && mPhase == HALF && mStart == 0)
      check("R3", int'(offsetPpm), -peakOf(mSel));            // R3 / R2 peak
    prevOff = int'(offsetPpm);
  end

  task automatic runCycles(input int n, input int tickEvery);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      tick = (i % tickEvery) == 0;
    end
  endtask

  initial begin
    reqTag = "R7";
    runCycles(3, 1);
    @(negedge clk); #1;
    rst = 1'b0; en = 1'b1; tick = 1'b1;
    reqTag = "R4";
    runCycles(PERIOD + 10, 1);
    // Change depth mid-period: must wait for boundary
    reqTag = "R5";
    spreadSel = 2'b01;
    runCycles(PERIOD, 1);
    spreadSel = 2'b10;
    runCycles(60, 1);
    spreadSel = 2'b00;
    runCycles(30, 1);
    spreadSel = 2'b10;
    reqTag = "R2";
    runCycles(PERIOD + 20, 1);
    spreadSel = 2'b11;
    runCycles(2 * PERIOD, 1);
    // Sparse ticks: holding between steps
    reqTag = "R8";
    spreadSel = 2'b10;
    runCycles(3 * PERIOD + 40, 3);
    // Disable mid-period, then resume
    reqTag = "R7";
    en = 1'b0;
    runCycles(5, 1);
    en = 1'b1;
    spreadSel = 2'b01;
    runCycles(300, 1);
    rst = 1'b1;
    runCycles(2, 1);
    rst = 1'b0;
    reqTag = "R9";
    runCycles(PERIOD + 5, 1);
    @(negedge clk);
    report();
  end

endmodule